// File: doc/BRIEF.md
# Stream Data Width Converter

This block re-packs a stream that uses a valid/ready handshake from one word width to another. When the input is wider than the output, each wide word is held and sent out as a series of narrow slices. When the input is narrower, consecutive narrow words are collected into one wide word, which is sent once it is complete. The ratio between the two widths is the number of narrow beats that make up one wide word.

A single parameter picks the slice order for both directions. With that parameter set, the least significant slice travels first. With it clear, the most significant slice travels first. A narrowing instance followed by a widening instance with swapped widths and the same order therefore forms a pure delay line: every word comes out unchanged and in order, whatever stalls either side applies. Elaboration stops with an error when a width is zero, when the two widths are equal, or when the larger width is not an exact multiple of the smaller one.

Top module: `stream_width_conv`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is low and `in_ready` is high, and no partial word is held.
- R2: A word moves on a port only in a cycle where valid and ready are both high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R3: Narrowing with `LITTLE_FIRST`=1: slice k (k = 0 first) of a wide word w is w[k*OUT_W +: OUT_W].
- R4: Narrowing with `LITTLE_FIRST`=0: slice k of a wide word w is w[(RATIO-1-k)*OUT_W +: OUT_W], so the top slice goes first.
- R5: Widening: the first narrow beat received lands in bits [IN_W-1:0] when `LITTLE_FIRST`=1, and in the topmost IN_W bits when `LITTLE_FIRST`=0.
- R6: Widening: `out_valid` rises only after RATIO narrow beats have been accepted since reset or since the last wide word left.
- R7: Narrowing: `in_ready` is high in the cycle the last slice of a word transfers, so with the consumer always ready and a steady source, slices leave on consecutive cycles without a bubble.
- R8: A narrowing instance feeding a widening instance with swapped widths and the same order reproduces the input stream exactly, with no loss or duplication, under arbitrary stalls between the two and at the far end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Converter can take the input word |
| in_data | input | IN_W | Input word |
| out_valid | output | 1 | Output word is offered |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | OUT_W | Output word |

## Verification
On every cycle, assertions check that a stalled output holds its value and valid state, that the slice counters stay within the ratio, that an accepted wide word makes the output valid next cycle, and that a completed gather raises valid. Slice order, bit placement of gathered beats, the absence of bubbles between back-to-back words and loss-free round trips under stalls can only be shown by the bench. It drives two narrowing-then-widening chains, one for each order, compares every intermediate slice and every reassembled word against values computed arithmetically, and then verifies that nothing further emerges.

// File: rtl/scw_pkg.sv
package scw_pkg;

  function automatic int ratio_of(input int a, input int b);
    return (a > b) ? a / b : b / a;
  endfunction

  // counter width, never below one bit
  function automatic int cnt_bits(input int r);
    return (r <= 2) ? 1 : $clog2(r);
  endfunction

  function automatic bit widths_ok(input int a, input int b);
    if (a <= 0 || b <= 0 || a == b) return 1'b0;
    return (a > b) ? (a % b == 0) : (b % a == 0);
  endfunction

endpackage

// File: rtl/scw_split.sv
module scw_split #(
  parameter int  WIDE   = 16,
  parameter int  NARROW = 4,
  parameter bit  LITTLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIDE-1:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NARROW-1:0] out_data
);
  localparam int RATIO = scw_pkg::ratio_of(WIDE, NARROW);
  localparam int CW    = scw_pkg::cnt_bits(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [WIDE-1:0] hold_q, hold_shift;
  logic [CW-1:0]   cnt_q;
  logic            full_q;
  logic            take_in, give_out, at_last;

  assign at_last  = (cnt_q == LAST);
  assign give_out = full_q && out_ready;
  assign in_ready = !full_q || (out_ready && at_last);
  assign take_in  = in_valid && in_ready;
  assign out_valid = full_q;

  generate
    if (LITTLE) begin : g_low_first
      assign out_data   = hold_q[NARROW-1:0];
      assign hold_shift = {{NARROW{1'b0}}, hold_q[WIDE-1:NARROW]};
    end else begin : g_high_first
      assign out_data   = hold_q[WIDE-1 -: NARROW];
      assign hold_shift = {hold_q[WIDE-NARROW-1:0], {NARROW{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (take_in) begin
      full_q <= 1'b1;
      cnt_q  <= '0;
      hold_q <= in_data;
    end else if (give_out) begin
      hold_q <= hold_shift;
      if (at_last) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: stalled slice is held
  p_hold_stalled_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: an accepted wide word is offered on the next cycle
  p_load_offers_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R3 R4: slice index never passes the ratio
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/scw_gather.sv
module scw_gather #(
  parameter int  WIDE   = 16,
  parameter int  NARROW = 4,
  parameter bit  LITTLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NARROW-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE-1:0]   out_data
);
  localparam int RATIO = scw_pkg::ratio_of(WIDE, NARROW);
  localparam int CW    = scw_pkg::cnt_bits(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [WIDE-1:0] acc_q, acc_next;
  logic [CW-1:0]   cnt_q;
  logic            full_q;
  logic            take_in, give_out, at_last;

  assign at_last   = (cnt_q == LAST);
  assign give_out  = full_q && out_ready;
  assign in_ready  = !full_q || out_ready;
  assign take_in   = in_valid && in_ready;
  assign out_valid = full_q;
  assign out_data  = acc_q;

  generate
    if (LITTLE) begin : g_low_first
      // earliest beat drifts down to the bottom
      assign acc_next = {in_data, acc_q[WIDE-1:NARROW]};
    end else begin : g_high_first
      // earliest beat drifts up to the top
      assign acc_next = {acc_q[WIDE-NARROW-1:0], in_data};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else begin
      if (take_in) begin
        acc_q <= acc_next;
        cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end
      if (take_in && at_last) full_q <= 1'b1;
      else if (give_out)      full_q <= 1'b0;
    end
  end

  // R2: stalled wide word is held
  p_hold_stalled_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: the final beat of a group produces a valid word
  p_complete_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && at_last) |=> out_valid);

  // R6: valid cannot appear without a beat arriving
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !(in_valid && in_ready)) |=> !out_valid);

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/stream_width_conv.sv
module stream_width_conv #(
  parameter int IN_W         = 16,
  parameter int OUT_W        = 4,
  parameter bit LITTLE_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam bit NARROWING = (IN_W > OUT_W);

  generate
    if (!scw_pkg::widths_ok(IN_W, OUT_W)) begin : g_bad_widths
      $error("stream_width_conv: widths must be nonzero, unequal and integer multiples");
    end

    if (NARROWING) begin : g_split
      scw_split #(.WIDE(IN_W), .NARROW(OUT_W), .LITTLE(LITTLE_FIRST)) u_split (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));
    end else begin : g_gather
      scw_gather #(.WIDE(OUT_W), .NARROW(IN_W), .LITTLE(LITTLE_FIRST)) u_gather (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));
    end
  endgenerate

  // R1: nothing offered on the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/conv_pair_check.sv
module conv_pair_check #(
  parameter bit LE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  output int   checks,
  output int   errors,
  output logic done
);
  localparam int W  = 16;
  localparam int NW = 4;
  localparam int R  = W / NW;
  localparam int NWORDS = 40;
  localparam int FAST = 8;

  logic          src_valid, src_ready;
  logic [W-1:0]  src_data;
  logic          mid_valid, mid_ready, up_valid, up_ready, gate;
  logic [NW-1:0] mid_data;
  logic          fin_valid, fin_ready;
  logic [W-1:0]  fin_data;

  assign up_valid  = mid_valid & gate;
  assign mid_ready = up_ready & gate;

  stream_width_conv #(.IN_W(W), .OUT_W(NW), .LITTLE_FIRST(LE)) i_stream_width_conv (
    .clk(clk), .rst(rst),
    .in_valid(src_valid), .in_ready(src_ready), .in_data(src_data),
    .out_valid(mid_valid), .out_ready(mid_ready), .out_data(mid_data));

  stream_width_conv #(.IN_W(NW), .OUT_W(W), .LITTLE_FIRST(LE)) i_up (
    .clk(clk), .rst(rst),
    .in_valid(up_valid), .in_ready(up_ready), .in_data(mid_data),
    .out_valid(fin_valid), .out_ready(fin_ready), .out_data(fin_data));

  function automatic logic [W-1:0] word_of(input int n);
    if (n == 0) return '0;
    if (n == 1) return '1;
    return W'(n * 40503 + 12345);
  endfunction

  function automatic logic [NW-1:0] slice_of(input int s);
    logic [W-1:0] w;
    int k;
    w = word_of(s / R);
    k = s % R;
    if (LE) return w[k*NW +: NW];
    return w[(R-1-k)*NW +: NW];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (order LE=%0d): actual %0h expected %0h", req, LE, act, exp);
    end
  endtask

  initial begin
    int sidx, midx, fidx, cyc, first_cyc;
    bit prev_stall;
    logic [NW-1:0] prev_data;
    checks = 0; errors = 0; done = 1'b0;
    src_valid = 1'b0; src_data = '0; gate = 1'b0; fin_ready = 1'b0;
    sidx = 0; midx = 0; fidx = 0; cyc = 0; first_cyc = 0;
    prev_stall = 1'b0; prev_data = '0;
    @(negedge rst);
    @(negedge clk);
    #8;
    // R1 reset state on both instances
    chk(!mid_valid && src_ready, "R1 narrowing idle", {mid_valid, src_ready}, 2'b01);
    chk(!fin_valid && up_ready, "R1 widening idle", {fin_valid, up_ready}, 2'b01);
    while (fidx < NWORDS && cyc < 4000) begin
      @(negedge clk);
      src_valid = (sidx < NWORDS) && ((sidx < FAST) || (cyc % 5 != 3));
      src_data  = word_of(sidx);
      gate      = (midx < FAST * R) || (cyc % 3 != 0);
      fin_ready = (fidx < FAST) || (cyc % 4 < 2);
      #8;
      if (prev_stall) // R2 stalled slice held
        chk(mid_valid && mid_data == prev_data, "R2 hold while stalled",
            {mid_valid, mid_data}, {1'b1, prev_data});
      if (fin_valid && fin_ready) begin
        chk(midx >= R * (fidx + 1), "R6 word only after all beats", midx, R * (fidx + 1));
        chk(fin_data == word_of(fidx), "R5 R8 round trip word", fin_data, word_of(fidx));
        fidx++;
      end
      if (mid_valid && mid_ready) begin
        chk(mid_data == slice_of(midx), LE ? "R3 low slice first" : "R4 high slice first",
            mid_data, slice_of(midx));
        if (midx == 0) first_cyc = cyc;
        if (midx == FAST * R - 1)
          chk(cyc - first_cyc == FAST * R - 1, "R7 back-to-back slices", cyc - first_cyc,
              FAST * R - 1);
        midx++;
      end
      prev_stall = mid_valid && !mid_ready;
      prev_data  = mid_data;
      if (src_valid && src_ready) sidx++;
      cyc++;
    end
    chk(fidx == NWORDS, "R8 all words delivered", fidx, NWORDS);
    // R8 nothing extra emerges
    src_valid = 1'b0; gate = 1'b1; fin_ready = 1'b1;
    for (int i = 0; i < 3 * R; i++) begin
      @(negedge clk);
      #8;
      if (fin_valid || mid_valid) begin
        chk(1'b0, "R8 no duplicate output", {mid_valid, fin_valid}, 0);
      end
    end
    chk(midx == NWORDS * R, "R8 slice count", midx, NWORDS * R);
    done = 1'b1;
  end

endmodule

// File: tb/test_stream_width_conv.sv
module test_stream_width_conv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks_le, errors_le, checks_be, errors_be;
  logic done_le, done_be;

  always #10 clk = ~clk; // 50 MHz

  conv_pair_check #(.LE(1'b1)) u_le (
    .clk(clk), .rst(rst), .checks(checks_le), .errors(errors_le), .done(done_le));
  conv_pair_check #(.LE(1'b0)) u_be (
    .clk(clk), .rst(rst), .checks(checks_be), .errors(errors_be), .done(done_be));

  initial begin
    int cycles;
    int extra_err;
    extra_err = 0;
    cycles = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    while (!(done_le && done_be) && cycles < 20000) begin
      @(negedge clk);
      cycles++;
    end
    if (!(done_le && done_be)) begin
      extra_err = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors",
             checks_le + checks_be + extra_err, errors_le + errors_be + extra_err);
    $finish;
  end
endmodule